// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Target RAM

This block lets a microcontroller's external memory port reach a small byte-wide register RAM inside an FPGA. The host uses eight shared wires. It first presents an address there, marked by an address-valid strobe. It then moves one or more data bytes over the same wires, under an output-enable or write-enable strobe. The transfer is purely asynchronous: the host supplies no clock and the target has no wait line. The host may issue ordinary loads and stores or run DMA, so consecutive transfers come back to back.

All four active-low control inputs pass through a two-flop synchronizer, and the bus lines pass through a matching delay chain. Strobe edges are detected in the FPGA's own clock domain. A rising address-valid strobe latches the address. A rising write enable stores a byte at the latched address. A falling output enable makes the block drive the addressed byte until the host withdraws output enable or chip select. The shared pins are modelled as a separate input byte, output byte and drive-enable, which the pad ring turns into a tristate buffer.

Top module: `mxb_ram_slave`

## Requirements
- R1: After the synchronous active-high reset, `bus_oe` is 0.
- R2: When `adv_n` rises while `cs_n` is low, the byte on `bus_i` sampled just before the rise becomes the latched address. All address bits are used, so address 0xFF is valid.
- R3: When `we_n` rises while `cs_n` is low, the byte on `bus_i` sampled just before the rise is stored at the latched address.
- R4: When `oe_n` falls while `cs_n` is low, `bus_oe` becomes 1 and `bus_o` carries the byte stored at the latched address.
- R5: `bus_oe` returns to 0 within three clocks once `oe_n` or `cs_n` is high.
- R6: `bus_oe` is 0 while `we_n` or `adv_n` is low. A falling `oe_n` seen while `we_n` is low does not start a drive, even after `we_n` later rises.
- R7: While `cs_n` is high, `adv_n`, `we_n` and `oe_n` have no effect: the address, the memory and `bus_oe` are left unchanged.
- R8: Driving starts only on a falling `oe_n` with chip select low. Lowering `cs_n` while `oe_n` is already low does not drive the bus.
- R9: After a single address phase, any number of data phases (reads and writes mixed) all use that address.
- R10: A write completes even if `we_n` and `cs_n` rise in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FPGA system clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable (read strobe), active low |
| we_n | input | 1 | Write enable, active low |
| bus_i | input | 8 | Shared address/data lines as seen at the pad input |
| bus_o | output | 8 | Read data for the pad output buffer |
| bus_oe | output | 1 | Pad drive enable; 0 means the lines float |

## Verification
A write commit and a deselect can land in the same synchronized cycle, because many hosts raise the write strobe and chip select together at the end of a store. The bench provokes this by releasing both pins on the same clock. It judges the result by selecting the block again, repeating the address phase and reading the byte back through the scoreboard. A lost write shows up as a mismatch. Strobes issued while deselected, and an output enable that falls during a write, are also judged at the ports: the bench watches `bus_oe` and then reads back through a later cycle the address and memory those strobes could have disturbed.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef struct packed {
    logic cs;
    logic adv;
    logic oe;
    logic we;
  } mxb_ctl_t;

  localparam int unsigned CTL_W = $bits(mxb_ctl_t);
  localparam logic [CTL_W-1:0] CTL_IDLE = '1;
endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
  import mxb_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  mxb_ctl_t      ctl_s,
  input  logic [DW-1:0] bus_s,
  output mxb_ctl_t      ctl_p,
  output logic [AW-1:0] addr_q,
  output logic          cap_en,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          drive_q
);
  logic [DW-1:0] bus_p;
  logic          we_rise;
  logic          oe_fall;
  logic          hold_off;

  // previous synchronized sample, aligned with the bus delay chain
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_p <= mxb_ctl_t'(CTL_IDLE);
      bus_p <= '0;
    end else begin
      ctl_p <= ctl_s;
      bus_p <= bus_s;
    end
  end

  // address and write edges are qualified by chip select in the last
  // low-strobe sample, so a strobe releasing with chip select still counts
  assign cap_en   = ctl_s.adv & ~ctl_p.adv & ~ctl_p.cs;
  assign we_rise  = ctl_s.we  & ~ctl_p.we  & ~ctl_p.cs;
  assign oe_fall  = ~ctl_s.oe & ctl_p.oe   & ~ctl_s.cs;
  assign hold_off = ctl_s.cs | ctl_s.oe | ~ctl_s.we | ~ctl_s.adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (cap_en) begin
      addr_q <= bus_p[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en   <= we_rise;
      wr_data <= bus_p;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          drive_q <= 1'b0;
    else if (hold_off) drive_q <= 1'b0;
    else if (oe_fall)  drive_q <= 1'b1;
  end
endmodule

// File: rtl/mxb_ram.sv
module mxb_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/mxb_ram_slave.sv
module mxb_ram_slave
  import mxb_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe
);
  mxb_ctl_t         ctl_raw;
  logic [CTL_W-1:0] ctl_vec;
  mxb_ctl_t         ctl_s;
  mxb_ctl_t         ctl_p;
  logic [DW-1:0]    bus_s;
  logic [AW-1:0]    addr_q;
  logic             cap_en;
  logic             wr_en;
  logic [DW-1:0]    wr_data;
  logic             drive_q;
  logic [DW-1:0]    rd_q;

  assign ctl_raw = '{cs: cs_n, adv: adv_n, oe: oe_n, we: we_n};

  mxb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_vec)
  );
  assign ctl_s = mxb_ctl_t'(ctl_vec);

  mxb_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .d(bus_i), .q(bus_s)
  );

  mxb_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_s(ctl_s), .bus_s(bus_s), .ctl_p(ctl_p),
    .addr_q(addr_q), .cap_en(cap_en), .wr_en(wr_en), .wr_data(wr_data),
    .drive_q(drive_q)
  );

  mxb_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(addr_q), .wr_data(wr_data),
    .rd_addr(addr_q), .rd_q(rd_q)
  );

  assign bus_o  = rd_q;
  assign bus_oe = drive_q;
endmodule

// File: rtl/mxb_chk.sv
module mxb_chk
  import mxb_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input mxb_ctl_t      ctl_s,
  input mxb_ctl_t      ctl_p,
  input logic [AW-1:0] addr_q,
  input logic          cap_en,
  input logic          wr_en,
  input logic          bus_oe
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !bus_oe);

  a_r2_addr_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_q) |-> $past(cap_en));

  a_r4_drive_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(!ctl_s.oe && !ctl_s.cs));

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (ctl_s.oe || ctl_s.cs) |=> !bus_oe);

  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.we || !ctl_s.adv) |=> !bus_oe);

  a_r7_write_needs_select: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(ctl_p.cs));
endmodule

bind mxb_ram_slave mxb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ctl_s(ctl_s), .ctl_p(ctl_p), .addr_q(addr_q),
  .cap_en(cap_en), .wr_en(wr_en), .bus_oe(bus_oe)
);

// File: tb/mxb_ram_slave_tb_top.sv
`timescale 1ns/1ps
module mxb_ram_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] bus_i = '0;
  logic [7:0] bus_o;
  logic       bus_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  mxb_ram_slave dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each new drive must match the oldest expected read
  always @(negedge clk) begin
    if (!rst && bus_oe && !prev_oe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R7/R8 unexpected drive", 1, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(bus_o == e, "R4 read data", bus_o, e);
      end
    end
    prev_oe <= bus_oe;
  end

  task automatic addr_phase(input logic [7:0] a);
    bus_i = a; tick(2);
    adv_n = 1'b0; tick(4);
    adv_n = 1'b1; tick(2);
  endtask

  task automatic write_phase(input logic [7:0] d, input bit drop_cs);
    bus_i = d; tick(2);
    we_n = 1'b0; tick(4);
    we_n = 1'b1;
    if (drop_cs) cs_n = 1'b1;
    tick(3);
  endtask

  task automatic read_phase(input logic [7:0] e);
    exp_q.push_back(e);
    oe_n = 1'b0; tick(6);
    oe_n = 1'b1; tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] av [4] = '{8'h00, 8'hFF, 8'h5A, 8'h01};
    logic [7:0] dv [4] = '{8'h3C, 8'hC3, 8'hFF, 8'h00};
    tick(5);
    rst = 1'b0;
    tick(3);
    check(bus_oe == 1'b0, "R1 idle after reset", bus_oe, 0);

    // R2 R3 R4: distinct addresses and data patterns, incl. address 0xFF
    cs_n = 1'b0; tick(3);
    for (int i = 0; i < 4; i++) begin
      addr_phase(av[i]); write_phase(dv[i], 1'b0);
    end
    for (int i = 3; i >= 0; i--) begin
      addr_phase(av[i]); read_phase(dv[i]);
    end

    // R9: several data phases behind a single address phase
    addr_phase(8'h10);
    write_phase(8'h11, 1'b0); read_phase(8'h11);
    write_phase(8'h22, 1'b0); read_phase(8'h22); read_phase(8'h22);

    // R5: deselect while output enable is still low releases the bus
    exp_q.push_back(8'h22);
    oe_n = 1'b0; tick(6);
    check(bus_oe == 1'b1, "R4 drive on falling oe_n", bus_oe, 1);
    cs_n = 1'b1; tick(4);
    check(bus_oe == 1'b0, "R5 release on cs_n high", bus_oe, 0);
    oe_n = 1'b1; tick(3);

    // R8: chip select lowered under an already-low output enable
    oe_n = 1'b0; tick(3);
    cs_n = 1'b0; tick(6);
    check(bus_oe == 1'b0, "R8 no drive without oe_n edge", bus_oe, 0);
    oe_n = 1'b1; tick(4);

    // R6: output enable falls during a write phase
    bus_i = 8'h33; tick(2);
    we_n = 1'b0; tick(3);
    oe_n = 1'b0; tick(5);
    check(bus_oe == 1'b0, "R6 no drive while we_n low", bus_oe, 0);
    we_n = 1'b1; tick(5);
    check(bus_oe == 1'b0, "R6 no drive after late we_n rise", bus_oe, 0);
    oe_n = 1'b1; tick(4);
    read_phase(8'h33); // R3: that write still landed at 0x10

    // R7: strobes while deselected must not touch address, memory or bus
    cs_n = 1'b1; tick(3);
    addr_phase(8'h44);
    write_phase(8'h99, 1'b0);
    oe_n = 1'b0; tick(6);
    check(bus_oe == 1'b0, "R7 no drive while deselected", bus_oe, 0);
    oe_n = 1'b1; tick(4);
    cs_n = 1'b0; tick(3);
    read_phase(8'h33); // R7: address stays 0x10, contents unchanged

    // R10: write enable and chip select released on the same clock
    addr_phase(8'h20);
    write_phase(8'h7E, 1'b1);
    tick(3);
    cs_n = 1'b0; tick(3);
    addr_phase(8'h20);
    read_phase(8'h7E);

    tick(5);
    check(exp_q.size() == 0, "R4 every read served", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule